// File: doc/BRIEF.md
# SAR Conversion Timing Controller

This block paces one 10-bit successive-approximation conversion. Software writes a 3-bit clock select and pulses a start request. The block then derives a per-bit period (the TAD) either by dividing the system clock by one of six power-of-two ratios or from an asynchronous tick produced by an on-die RC oscillator. It steps through a fixed frame of TAD periods: one period to disconnect the sample, ten periods of bit trials from the MSB down, and one period to store the result.

During the trials the block drives a trial code to an external DAC and comparator and reads back one comparator bit per period. When the frame ends it raises `done` and clears its own busy (start) bit. Two warnings are produced. One fires when the latched divider ratio gives a TAD shorter than the minimum for the configured system clock frequency. The other fires when the RC source is used with a fast system clock while the sleep input is not held for the whole conversion.

Top module: `sar_tad_sequencer`

## Requirements
- R1: With a divider source of ratio N, `done` rises exactly 12*N clock cycles after the cycle in which a start is accepted (`busy` rises), and stays low one cycle earlier.
- R2: Select codes map to divider ratios as 000→2, 100→4, 001→8, 101→16, 010→32, 110→64 system clocks per TAD.
- R3: Select codes 011 and 111 both use the RC tick. After two synchronizer flops, each rising edge of `rc_tick_async` is one TAD, so a conversion ends after twelve such edges.
- R4: The select field is captured when a start is accepted. Changing `clk_sel` during a conversion changes neither the TAD in use nor the length of the frame.
- R5: A `go_set` pulse while `busy` is high is ignored: the frame length and the result are unchanged and `done` is not cleared.
- R6: When the frame ends, `done` goes high and `busy` goes low in the same cycle. `done` is cleared when the next start is accepted.
- R7: Bits are resolved MSB first. For each trial bit, `cmp_in`=1 keeps the bit set and `cmp_in`=0 clears it. With a comparator that reports `dac_code` <= input, `result` equals the input code.
- R8: `tad_too_short` is set at start when the selected divider TAD (ratio / OSC_HZ) is below MIN_TAD_NS. It stays clear in RC mode and holds its value until the next start.
- R9: When OSC_HZ exceeds 1 MHz, `acc_warn` is set if `sleep` is low during any busy cycle of an RC-mode conversion. It is cleared at the next start and never set in divider mode.
- R10: Reset clears `busy`, `done`, `result`, `tad_too_short` and `acc_warn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_set | input | 1 | Start request pulse (sets the busy bit when idle) |
| clk_sel | input | 3 | TAD source select |
| rc_tick_async | input | 1 | Asynchronous RC oscillator tick |
| sleep | input | 1 | High while the system is asleep |
| cmp_in | input | 1 | Comparator result for the current trial code |
| dac_code | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress (hardware-cleared start bit) |
| done | output | 1 | Conversion complete, result valid |
| result | output | 10 | Converted code |
| tad_too_short | output | 1 | Latched divider TAD below the minimum |
| acc_warn | output | 1 | RC conversion ran without sleep held |

## Verification
Two functions can fall in the same cycle: the last TAD strobe that ends a frame and a new start request. The bench counts cycles from the accepted start and drives `go_set` into exactly the edge on which the twelfth strobe arrives. It then expects `done` high and `busy` low at that edge, and expects both to stay that way afterwards, because the request was seen while still busy. A start pulse in the middle of a frame and a select change in the middle of a frame are judged the same way: the bench checks that the exact 12*N finishing cycle and the scoreboard result do not move.

// File: rtl/sar_tad_sequencer.sv
module sar_tad_sequencer #(
  parameter int unsigned OSC_HZ     = 20_000_000,
  parameter int unsigned MIN_TAD_NS = 1600,
  parameter int unsigned BITS       = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_set,
  input  logic [2:0]      clk_sel,
  input  logic            rc_tick_async,
  input  logic            sleep,
  input  logic            cmp_in,
  output logic [BITS-1:0] dac_code,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] result,
  output logic            tad_too_short,
  output logic            acc_warn
);

  localparam int unsigned FRAME   = BITS + 2;
  localparam int unsigned ST_W    = $clog2(FRAME + 1);
  localparam int unsigned DIV_W   = 6;
  localparam bit          RC_FAST = OSC_HZ > 1_000_000;

  function automatic logic short_tad(input logic [2:0] s);
    longint unsigned r;
    if (&s[1:0]) return 1'b0;
    r = longint'(2) << (2 * s[1:0] + s[2]);
    return r * 64'd1_000_000_000 < longint'(MIN_TAD_NS) * longint'(OSC_HZ);
  endfunction

  logic [2:0]       sel_q;
  logic [DIV_W-1:0] div_cnt;
  logic [ST_W-1:0]  step;
  logic [2:0]       rc_sync;
  logic [BITS-1:0]  trial;

  wire              rc_mode = &sel_q[1:0];
  wire  [2:0]       shamt   = {sel_q[1:0], 1'b0} + {2'b0, sel_q[2]};
  wire  [DIV_W:0]   ratio   = (DIV_W+1)'(2) << shamt;
  wire              div_hit = div_cnt == DIV_W'(ratio - 1'b1);
  wire              rc_edge = rc_sync[1] & ~rc_sync[2];
  wire              strobe  = busy & (rc_mode ? rc_edge : div_hit);
  wire              accept  = go_set & ~busy;
  wire  [ST_W-1:0]  idx     = ST_W'(BITS) - step;

  assign dac_code = trial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q         <= '0;
      div_cnt       <= '0;
      step          <= '0;
      rc_sync       <= '0;
      trial         <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      result        <= '0;
      tad_too_short <= 1'b0;
      acc_warn      <= 1'b0;
    end else begin
      rc_sync <= {rc_sync[1:0], rc_tick_async};
      if (accept) begin
        busy          <= 1'b1;
        done          <= 1'b0;
        sel_q         <= clk_sel;
        div_cnt       <= '0;
        step          <= '0;
        trial         <= '0;
        tad_too_short <= short_tad(clk_sel);
        acc_warn      <= 1'b0;
      end else if (busy) begin
        div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        if (RC_FAST && rc_mode && !sleep) acc_warn <= 1'b1;
        if (strobe) begin
          step <= step + 1'b1;
          if (step == '0) begin
            trial[BITS-1] <= 1'b1;
          end else if (step <= ST_W'(BITS)) begin
            trial[idx] <= cmp_in;
            if (idx != '0) trial[idx - 1'b1] <= 1'b1;
          end else begin
            result <= trial;
            done   <= 1'b1;
            busy   <= 1'b0;
          end
        end
      end
    end
  end

  a_r1_step_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step < ST_W'(FRAME));

  a_r4_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(sel_q));

  a_r5_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && go_set |=> $stable(sel_q) && !$rose(busy));

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  a_r9_warn_rc_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_warn) |-> rc_mode);

endmodule

// File: tb/test_sar_tad_sequencer.sv
`timescale 1ns/1ps
module test_sar_tad_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go_set = 1'b0;
  logic [2:0] clk_sel = 3'b000;
  logic       rc_tick_async = 1'b0;
  logic       sleep = 1'b0;
  logic       cmp_in;
  logic [9:0] dac_code, result;
  logic       busy, done, tad_too_short, acc_warn;
  logic [9:0] vin = '0;

  int n_cmp = 0;
  int n_mis = 0;
  logic [9:0] exp_q[$];
  logic prev_done = 1'b0;

  sar_tad_sequencer i_sar_tad_sequencer (
    .clk(clk), .rst_n(rst_n), .go_set(go_set), .clk_sel(clk_sel),
    .rc_tick_async(rc_tick_async), .sleep(sleep), .cmp_in(cmp_in),
    .dac_code(dac_code), .busy(busy), .done(done), .result(result),
    .tad_too_short(tad_too_short), .acc_warn(acc_warn));

  always #5 clk = ~clk;
  initial forever #70 rc_tick_async = ~rc_tick_async;
  assign cmp_in = dac_code <= vin;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  endtask

  // monitor: pops one expected result per rising done (R7)
  always @(negedge clk) begin
    if (rst_n && done && !prev_done) begin
      if (exp_q.size() == 0) chk("R7 unexpected done", 1, 0);
      else chk("R7 result", result, exp_q.pop_front());
    end
    prev_done <= done;
  end

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'b000: return 2;  3'b100: return 4;
      3'b001: return 8;  3'b101: return 16;
      3'b010: return 32; default: return 64;
    endcase
  endfunction

  task automatic start(input logic [2:0] code, input logic [9:0] v);
    vin = v;
    exp_q.push_back(v);
    @(negedge clk); go_set = 1'b1; clk_sel = code;
    @(negedge clk); go_set = 1'b0;
  endtask

  // mode: 0 plain, 1 select change mid-frame, 2 go mid-frame, 3 go on final edge
  task automatic run_div(input logic [2:0] code, input logic [9:0] v, input int mode);
    int n;
    n = ratio_of(code);
    start(code, v);
    chk("R6 busy after start", busy, 1);
    chk("R6 done cleared at start", done, 0);
    chk("R8 too_short", tad_too_short, (n * 50 < 1600) ? 1 : 0);
    for (int k = 1; k < 12 * n; k++) begin
      @(negedge clk);
      go_set = (mode == 2 && k == 5) || (mode == 3 && k == 12 * n - 1);
      if (mode == 1 && k == 3) clk_sel = (code == 3'b110) ? 3'b000 : 3'b110;
    end
    chk("R1 done low one cycle early", done, 0);
    chk("R5 busy held", busy, 1);
    @(negedge clk); go_set = 1'b0;
    chk("R1 R2 done at 12*N", done, 1);
    chk("R6 busy cleared at done", busy, 0);
    if (mode == 3) begin
      repeat (3) @(negedge clk);
      chk("R5 go on final edge ignored busy", busy, 0);
      chk("R5 go on final edge ignored done", done, 1);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_rc(input logic [2:0] code, input logic [9:0] v, input logic slp);
    int cyc;
    sleep = slp;
    start(code, v);
    cyc = 1;
    chk("R8 too_short clear in RC", tad_too_short, 0);
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R3 rc done", done, 1);
    chk("R3 rc frame length", (cyc >= 150 && cyc <= 180) ? 1 : 0, 1);
    chk("R9 acc_warn", acc_warn, slp ? 0 : 1);
    sleep = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy reset", busy, 0);
    chk("R10 done reset", done, 0);
    chk("R10 result reset", result, 0);
    chk("R10 warnings reset", {tad_too_short, acc_warn}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_div(3'b000, 10'h2AA, 0);
    run_div(3'b100, 10'h155, 1);
    run_div(3'b001, 10'h3FF, 0);
    run_div(3'b101, 10'h000, 2);
    run_div(3'b010, 10'h001, 3);
    run_div(3'b110, 10'h200, 0);
    chk("R9 no warn in divider mode", acc_warn, 0);
    run_rc(3'b011, 10'h1C3, 1'b0);
    run_rc(3'b111, 10'h0F0, 1'b1);
    chk("R7 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule